// File: doc/BRIEF.md
# Handle Translation Table with FIFO Pointers

This block stands between accelerator ports and a pool of shared SRAM words. No accelerator names a physical address. Each request carries a handle number, and the table turns that number into an SRAM word address using the configuration stored for that handle. A handle is either a queue handle or a direct handle. Queue handles are used by push and pop. The table keeps a read pointer, a write pointer and a fill count for each one, and updates them as requests are accepted. Direct handles take an offset inside their region.

Software writes the table through a plain configuration port. A write can create a handle, reconfigure a live handle or remove one. The translated result leaves the block on a valid/ready output stream. That result is an SRAM word address, a write strobe and an error code. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` drops while an unconsumed result is held back by `out_ready`, and also drops on any cycle where a configuration write is present. A result that is refused by the table still travels the output stream, with a non-zero error code and no write strobe.

Top module: `hxt_table`

## Requirements
- R1: After reset `out_valid` is low, `req_ready` is high and every handle is invalid, so any request then returns error code 1.
- R2: `req_ready` is high exactly when `cfg_en` is low and either `out_valid` is low or `out_ready` is high. A request accepted at a rising edge produces its result on the outputs from that same edge, with `out_valid` high.
- R3: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_addr`, `out_we` and `out_err` hold their values.
- R4: A pop (`req_op`=0) on a queue handle returns address base+read pointer with `out_we`=0. The read pointer then advances, wrapping to 0 when it reaches the handle size.
- R5: A push (`req_op`=1) on a queue handle returns address base+write pointer with `out_we`=1. The write pointer then advances, wrapping to 0 when it reaches the handle size.
- R6: A pop from an empty queue returns error code 2. A push to a queue that holds size entries returns error code 3. Neither changes any pointer.
- R7: A direct read (`req_op`=2) or write (`req_op`=3) returns base+`req_offset`, with `out_we` high only for the write. An offset at or beyond the size returns error code 4.
- R8: Any request naming an invalid handle returns error code 1.
- R9: A push or pop on a direct handle, or a direct read or write on a queue handle, returns error code 5.
- R10: A configuration write with `cfg_del`=0 sets the handle valid and loads its kind, base and size. It clears that handle's pointers and count, whether the handle was live or not. A write with `cfg_del`=1 makes the handle invalid.
- R11: Every result with a non-zero error code has `out_we`=0 and `out_addr`=0. A result with error code 0 is a translated access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Configuration write strobe |
| cfg_del | input | 1 | 1: remove handle, 0: create or reconfigure |
| cfg_id | input | ID_W | Handle being configured |
| cfg_fifo | input | 1 | 1: queue handle, 0: direct handle |
| cfg_base | input | AW | First SRAM word of the region |
| cfg_size | input | AW+1 | Region size in words |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_op | input | 2 | 0 pop, 1 push, 2 direct read, 3 direct write |
| req_id | input | ID_W | Handle named by the request |
| req_offset | input | AW | Offset for direct requests |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | AW | Translated SRAM word address |
| out_we | output | 1 | 1: write the word, 0: read it |
| out_err | output | 3 | 0 ok, 1 bad handle, 2 empty, 3 full, 4 range, 5 wrong kind |

## Verification
The checks assume that software keeps each handle's base+size inside the SRAM, and that it does not reconfigure a handle whose queued data is still wanted. Sizes above 2^AW are also assumed not to occur. The stimulus only ever creates regions that fit, and only reconfigures handles whose contents no longer matter. The stream properties assume that the consumer is allowed to stall for any length of time. The bench drives `out_ready` low across several cycles, with a second request waiting, to exercise that case.

// File: rtl/hxt_pkg.sv
package hxt_pkg;
  typedef enum logic [1:0] {
    OP_POP  = 2'd0,
    OP_PUSH = 2'd1,
    OP_RD   = 2'd2,
    OP_WR   = 2'd3
  } hxt_op_e;

  typedef enum logic [2:0] {
    ERR_NONE   = 3'd0,
    ERR_BAD_ID = 3'd1,
    ERR_EMPTY  = 3'd2,
    ERR_FULL   = 3'd3,
    ERR_RANGE  = 3'd4,
    ERR_KIND   = 3'd5
  } hxt_err_e;
endpackage

// File: rtl/hxt_entry.sv
// One handle's configuration and queue state.
module hxt_entry #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic          cfg_del,
  input  logic          cfg_fifo,
  input  logic [AW-1:0] cfg_base,
  input  logic [AW:0]   cfg_size,
  input  logic          adv_pop,
  input  logic          adv_push,
  output logic          valid,
  output logic          is_fifo,
  output logic [AW-1:0] base,
  output logic [AW:0]   size,
  output logic [AW-1:0] head,
  output logic [AW-1:0] tail,
  output logic [AW:0]   count
);
  function automatic logic [AW-1:0] step(input logic [AW-1:0] p, input logic [AW:0] lim);
    logic [AW:0] p1;
    p1 = {1'b0, p} + 1'b1;
    return (p1 >= lim) ? '0 : p1[AW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      is_fifo <= 1'b0;
      base    <= '0;
      size    <= '0;
      head    <= '0;
      tail    <= '0;
      count   <= '0;
    end else if (cfg_wr) begin
      valid   <= 1'b1;
      is_fifo <= cfg_fifo;
      base    <= cfg_base;
      size    <= cfg_size;
      head    <= '0;
      tail    <= '0;
      count   <= '0;
    end else if (cfg_del) begin
      valid   <= 1'b0;
      head    <= '0;
      tail    <= '0;
      count   <= '0;
    end else begin
      if (adv_pop)  head <= step(head, size);
      if (adv_push) tail <= step(tail, size);
      case ({adv_push, adv_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/hxt_resolve.sv
// Combinational translation of one request against one selected entry.
module hxt_resolve
  import hxt_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          e_valid,
  input  logic          e_fifo,
  input  logic [AW-1:0] e_base,
  input  logic [AW:0]   e_size,
  input  logic [AW-1:0] e_head,
  input  logic [AW-1:0] e_tail,
  input  logic [AW:0]   e_count,
  input  logic [1:0]    op,
  input  logic [AW-1:0] offset,
  output logic [AW-1:0] addr,
  output logic          we,
  output logic [2:0]    err,
  output logic          want_pop,
  output logic          want_push
);
  hxt_op_e  op_e;
  hxt_err_e err_e;

  always_comb begin
    op_e      = hxt_op_e'(op);
    err_e     = ERR_NONE;
    addr      = '0;
    we        = 1'b0;
    want_pop  = 1'b0;
    want_push = 1'b0;
    if (!e_valid) begin
      err_e = ERR_BAD_ID;
    end else begin
      unique case (op_e)
        OP_POP: begin
          if (!e_fifo)            err_e = ERR_KIND;
          else if (e_count == '0) err_e = ERR_EMPTY;
          else begin
            addr     = e_base + e_head;
            want_pop = 1'b1;
          end
        end
        OP_PUSH: begin
          if (!e_fifo)                err_e = ERR_KIND;
          else if (e_count >= e_size) err_e = ERR_FULL;
          else begin
            addr      = e_base + e_tail;
            we        = 1'b1;
            want_push = 1'b1;
          end
        end
        OP_RD, OP_WR: begin
          if (e_fifo)                         err_e = ERR_KIND;
          else if ({1'b0, offset} >= e_size)  err_e = ERR_RANGE;
          else begin
            addr = e_base + offset;
            we   = (op_e == OP_WR);
          end
        end
        default: err_e = ERR_KIND;
      endcase
    end
    err = err_e;
  end
endmodule

// File: rtl/hxt_table.sv
module hxt_table #(
  parameter int NUM_HANDLES = 8,
  parameter int AW          = 10,
  localparam int ID_W = (NUM_HANDLES > 1) ? $clog2(NUM_HANDLES) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_en,
  input  logic            cfg_del,
  input  logic [ID_W-1:0] cfg_id,
  input  logic            cfg_fifo,
  input  logic [AW-1:0]   cfg_base,
  input  logic [AW:0]     cfg_size,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [1:0]      req_op,
  input  logic [ID_W-1:0] req_id,
  input  logic [AW-1:0]   req_offset,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [AW-1:0]   out_addr,
  output logic            out_we,
  output logic [2:0]      out_err
);
  logic          accept;
  logic          e_valid [NUM_HANDLES];
  logic          e_fifo  [NUM_HANDLES];
  logic [AW-1:0] e_base  [NUM_HANDLES];
  logic [AW:0]   e_size  [NUM_HANDLES];
  logic [AW-1:0] e_head  [NUM_HANDLES];
  logic [AW-1:0] e_tail  [NUM_HANDLES];
  logic [AW:0]   e_count [NUM_HANDLES];

  logic          s_valid, s_fifo;
  logic [AW-1:0] s_base, s_head, s_tail;
  logic [AW:0]   s_size, s_count;

  logic [AW-1:0] r_addr;
  logic          r_we, r_pop, r_push;
  logic [2:0]    r_err;

  assign req_ready = !cfg_en && (!out_valid || out_ready);
  assign accept    = req_valid && req_ready;

  for (genvar g = 0; g < NUM_HANDLES; g++) begin : g_ent
    logic hit_cfg, hit_req;
    assign hit_cfg = cfg_en && (cfg_id == ID_W'(g));
    assign hit_req = accept && (req_id == ID_W'(g));
    hxt_entry #(.AW(AW)) i_entry (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_wr   (hit_cfg && !cfg_del),
      .cfg_del  (hit_cfg && cfg_del),
      .cfg_fifo (cfg_fifo),
      .cfg_base (cfg_base),
      .cfg_size (cfg_size),
      .adv_pop  (hit_req && r_pop),
      .adv_push (hit_req && r_push),
      .valid    (e_valid[g]),
      .is_fifo  (e_fifo[g]),
      .base     (e_base[g]),
      .size     (e_size[g]),
      .head     (e_head[g]),
      .tail     (e_tail[g]),
      .count    (e_count[g])
    );
  end

  always_comb begin
    s_valid = 1'b0;
    s_fifo  = 1'b0;
    s_base  = '0;
    s_size  = '0;
    s_head  = '0;
    s_tail  = '0;
    s_count = '0;
    for (int i = 0; i < NUM_HANDLES; i++) begin
      if (req_id == ID_W'(i)) begin
        s_valid = e_valid[i];
        s_fifo  = e_fifo[i];
        s_base  = e_base[i];
        s_size  = e_size[i];
        s_head  = e_head[i];
        s_tail  = e_tail[i];
        s_count = e_count[i];
      end
    end
  end

  hxt_resolve #(.AW(AW)) i_resolve (
    .e_valid   (s_valid),
    .e_fifo    (s_fifo),
    .e_base    (s_base),
    .e_size    (s_size),
    .e_head    (s_head),
    .e_tail    (s_tail),
    .e_count   (s_count),
    .op        (req_op),
    .offset    (req_offset),
    .addr      (r_addr),
    .we        (r_we),
    .err       (r_err),
    .want_pop  (r_pop),
    .want_push (r_push)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_we    <= 1'b0;
      out_err   <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_addr  <= r_addr;
      out_we    <= r_we;
      out_err   <= r_err;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/hxt_checker.sv
module hxt_checker #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_en,
  input logic          req_valid,
  input logic          req_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [AW-1:0] out_addr,
  input logic          out_we,
  input logic [2:0]    out_err
);
  assert_cfg_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |-> !req_ready);

  assert_stall_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !req_ready);

  assert_new_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !(req_valid && req_ready)) |=> !out_valid);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)
                                   && $stable(out_we) && $stable(out_err)));

  assert_err_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err != 3'd0) |-> (!out_we && out_addr == '0));

  assert_err_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_err <= 3'd5));
endmodule

bind hxt_table hxt_checker #(.AW(AW)) i_hxt_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_en    (cfg_en),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_addr  (out_addr),
  .out_we    (out_we),
  .out_err   (out_err)
);

// File: tb/test_hxt_table.sv
module test_hxt_table;
  localparam int CLK_PERIOD = 10;
  localparam int NH = 8;
  localparam int AW = 10;
  localparam int IW = 3;

  typedef struct packed {
    logic [1:0]    op;
    logic [IW-1:0] id;
    logic [AW-1:0] off;
    logic [AW-1:0] addr;
    logic          we;
    logic [2:0]    err;
  } vec_t;

  // handle 1: queue, base 100, size 3; handle 2: direct, base 200, size 4; handle 0 unused
  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 3'd1, 10'd0, 10'd0,   1'b0, 3'd2},  // R6 pop empty
    '{2'd1, 3'd1, 10'd0, 10'd100, 1'b1, 3'd0},  // R5
    '{2'd1, 3'd1, 10'd0, 10'd101, 1'b1, 3'd0},  // R5
    '{2'd1, 3'd1, 10'd0, 10'd102, 1'b1, 3'd0},  // R5
    '{2'd1, 3'd1, 10'd0, 10'd0,   1'b0, 3'd3},  // R6 push full
    '{2'd0, 3'd1, 10'd0, 10'd100, 1'b0, 3'd0},  // R4
    '{2'd1, 3'd1, 10'd0, 10'd100, 1'b1, 3'd0},  // R5 tail wrap
    '{2'd0, 3'd1, 10'd0, 10'd101, 1'b0, 3'd0},  // R4
    '{2'd0, 3'd1, 10'd0, 10'd102, 1'b0, 3'd0},  // R4
    '{2'd0, 3'd1, 10'd0, 10'd100, 1'b0, 3'd0},  // R4 head wrap
    '{2'd0, 3'd1, 10'd0, 10'd0,   1'b0, 3'd2},  // R6
    '{2'd2, 3'd2, 10'd3, 10'd203, 1'b0, 3'd0},  // R7 read
    '{2'd3, 3'd2, 10'd1, 10'd201, 1'b1, 3'd0},  // R7 write
    '{2'd2, 3'd2, 10'd4, 10'd0,   1'b0, 3'd4},  // R7 range
    '{2'd0, 3'd0, 10'd0, 10'd0,   1'b0, 3'd1},  // R8
    '{2'd1, 3'd2, 10'd0, 10'd0,   1'b0, 3'd5},  // R9
    '{2'd2, 3'd1, 10'd0, 10'd0,   1'b0, 3'd5}   // R9
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_en = 1'b0, cfg_del = 1'b0, cfg_fifo = 1'b0;
  logic [IW-1:0] cfg_id = '0;
  logic [AW-1:0] cfg_base = '0;
  logic [AW:0]   cfg_size = '0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_op = '0;
  logic [IW-1:0] req_id = '0;
  logic [AW-1:0] req_offset = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [AW-1:0] out_addr;
  logic out_we;
  logic [2:0] out_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hxt_table #(.NUM_HANDLES(NH), .AW(AW)) i_hxt_table (
    .clk(clk), .rst_n(rst_n),
    .cfg_en(cfg_en), .cfg_del(cfg_del), .cfg_id(cfg_id), .cfg_fifo(cfg_fifo),
    .cfg_base(cfg_base), .cfg_size(cfg_size),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_id(req_id), .req_offset(req_offset),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_we(out_we), .out_err(out_err)
  );

  task automatic check_bit(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic check_out(string tag, logic [AW-1:0] ea, logic ew, logic [2:0] ee);
    checks++;
    if (out_valid !== 1'b1 || out_addr !== ea || out_we !== ew || out_err !== ee) begin
      errors++;
      $display("FAIL %s: actual v=%0b addr=%0d we=%0b err=%0d expected v=1 addr=%0d we=%0b err=%0d",
               tag, out_valid, out_addr, out_we, out_err, ea, ew, ee);
    end
  endtask

  task automatic configure(logic [IW-1:0] id, logic del, logic fifo,
                           logic [AW-1:0] b, logic [AW:0] sz);
    @(negedge clk);
    cfg_en = 1'b1; cfg_del = del; cfg_id = id; cfg_fifo = fifo;
    cfg_base = b; cfg_size = sz;
    @(negedge clk);
    cfg_en = 1'b0; cfg_del = 1'b0;
  endtask

  // drive at a falling edge, accepted at the next rising edge, result sampled at the falling edge after
  task automatic issue(logic [1:0] op, logic [IW-1:0] id, logic [AW-1:0] off);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_id = id; req_offset = off;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_bit("R1 out_valid after reset", out_valid, 1'b0);
    check_bit("R1 req_ready after reset", req_ready, 1'b1);
    issue(2'd2, 3'd5, 10'd0);
    check_out("R1 handle invalid after reset", 10'd0, 1'b0, 3'd1);

    configure(3'd1, 1'b0, 1'b1, 10'd100, 11'd3);
    configure(3'd2, 1'b0, 1'b0, 10'd200, 11'd4);
    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].op, VECS[i].id, VECS[i].off);
      check_out($sformatf("vector %0d (R4-R9 table, R11)", i), VECS[i].addr, VECS[i].we, VECS[i].err);
    end

    // R2: configuration write blocks requests
    @(negedge clk);
    cfg_en = 1'b1; cfg_del = 1'b0; cfg_id = 3'd7; cfg_fifo = 1'b0;
    cfg_base = 10'd0; cfg_size = 11'd1;
    #1 check_bit("R2 ready low during cfg", req_ready, 1'b0);
    @(negedge clk);
    cfg_en = 1'b0;

    // R10: delete then access, recreate with pointers cleared
    configure(3'd1, 1'b1, 1'b0, 10'd0, 11'd0);
    issue(2'd0, 3'd1, 10'd0);
    check_out("R10 deleted handle", 10'd0, 1'b0, 3'd1);
    configure(3'd1, 1'b0, 1'b1, 10'd50, 11'd2);
    issue(2'd0, 3'd1, 10'd0);
    check_out("R10 recreated queue empty", 10'd0, 1'b0, 3'd2);
    configure(3'd2, 1'b0, 1'b0, 10'd300, 11'd8);
    issue(2'd2, 3'd2, 10'd7);
    check_out("R10 reconfigured base", 10'd307, 1'b0, 3'd0);

    // R3 / R2: back-pressure on the output stream
    @(negedge clk);
    out_ready = 1'b0;
    req_valid = 1'b1; req_op = 2'd1; req_id = 3'd1; req_offset = '0;
    @(negedge clk);
    check_out("R5 first push under stall", 10'd50, 1'b1, 3'd0);
    check_bit("R2 ready low while stalled", req_ready, 1'b0);
    repeat (3) @(negedge clk);
    check_out("R3 held while stalled", 10'd50, 1'b1, 3'd0);
    out_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check_out("R2 second push after release", 10'd51, 1'b1, 3'd0);
    @(negedge clk);
    check_bit("R2 output drains", out_valid, 1'b0);
    issue(2'd1, 3'd1, 10'd0);
    check_out("R6 full after two pushes", 10'd0, 1'b0, 3'd3);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule